// File: doc/BRIEF.md
# Serial-Fed Nonce Scan Controller

This block sits between a byte-wide serial link and a fully pipelined hash core that is outside the block. Mining work comes in as a 416-bit packet, one byte per handshake. When the last byte lands, the block latches the packet as the core's work and loads the packet's start nonce into a scan counter. From the next cycle on it hands the core one fresh nonce on every clock.

The core returns three 32-bit words per candidate, `PIPE_LATENCY` cycles after the nonce was issued. The block registers a hit when the XOR of the three words is zero. By default all 32 bits take part; setting `REDUCED_CMP` to 1 restricts the compare to the low 24 bits for low-difficulty runs. The block recovers the nonce behind a hit by subtracting the pipeline depth, plus the match register, from the running counter. It then sends that nonce back as four bytes over a valid/ready byte transmitter.

A new packet aborts the running scan at once, and hits from older work that are still in flight are discarded. A scan that passes 0xFFFFFFFF without new work drains the pipeline and then parks in an idle state.

Top module: `nonce_scan_ctrl`

## Requirements
- R1: A byte is accepted on every cycle that `rx_valid` is high. Bytes arrive most significant first. The 52nd byte completes the packet, and `core_work` holds the whole packet from the following cycle. The field layout is: target [415:384], start nonce [383:352], data [351:256], midstate [255:0].
- R2: In the cycle after a packet completes, `core_valid` is 1 and `core_nonce` equals the packet's start nonce. This holds whether the block was idle, scanning or draining.
- R3: While scanning, `core_nonce` rises by exactly one on every clock.
- R4: The core words for a candidate are sampled `PIPE_LATENCY` cycles after that candidate is issued. A hit requires `core_iv ^ core_st_a ^ core_st_b` to be zero in all 32 bits (default `REDUCED_CMP`=0), so a candidate that differs only in bits 31:24 is no hit. Core words that arrive when no valid candidate is in flight are ignored.
- R5: The reported nonce is the issued nonce whose words matched. This holds when the scan starts exactly at the answer, or 1 or 2 below it.
- R6: A packet that completes while a hit from the previous work is still in the pipeline or the match register causes that hit to be dropped, and never reported.
- R7: A hit is sent as 4 bytes, most significant first. `tx_valid` rises in the cycle after the hit is registered. Each byte holds steady on `tx_byte` until the cycle in which `tx_ready` is 1.
- R8: One hit that arrives while another is being sent is buffered and sent next. Any further hit that arrives while the buffer is full is dropped.
- R9: After reset, and after a scan issues nonce 0xFFFFFFFF with no new packet, `core_valid` is 0. In the wrap case, `idle` rises at the (`PIPE_LATENCY`+2)-th clock edge, counting the edge that ends the last issue cycle. Nonce 0 is not issued after the wrap. Hits on the last candidates are still reported correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Incoming packet byte |
| rx_valid | input | 1 | Byte strobe, one byte per high cycle |
| core_work | output | 416 | Latched work packet for the hash core |
| core_nonce | output | 32 | Nonce candidate issued to the core |
| core_valid | output | 1 | Candidate on `core_nonce` is valid this cycle |
| core_iv | input | 32 | Core result word, initial-value term |
| core_st_a | input | 32 | Core result word, first state term |
| core_st_b | input | 32 | Core result word, second state term |
| tx_byte | output | 8 | Outgoing result byte |
| tx_valid | output | 1 | `tx_byte` holds a result byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| idle | output | 1 | No scan running and pipeline drained |

## Verification
The bench models the hash core itself. It keeps its own delay line of issued nonces and drives result words that XOR to zero for chosen answers. Near misses carry differences only in the top byte, which separates a full compare from a truncated one.

Scans are started exactly on the answer and one and two below it, which exposes an off-by-one in the latency correction. Zero-XOR words are also driven while no candidate is in flight, which exposes a missing validity gate.

Three closely spaced hits are produced against a stalled transmitter to check the one-entry buffer and the drop rule. A second packet is timed to land while a hit is in the pipeline, to check the abort. A scan just below 0xFFFFFFFF checks reporting across the wrap and the drain into idle.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_RUN   = 2'd1,
        SC_DRAIN = 2'd2
    } scan_state_e;

endpackage

// File: rtl/nsc_pkt_rx.sv
module nsc_pkt_rx #(
    parameter int PKT_W = 416,
    parameter int NW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_byte,
    input  logic             rx_valid,
    output logic             done_o,
    output logic [NW-1:0]    start_o,
    output logic [PKT_W-1:0] work_o
);
    localparam int NBYTES = PKT_W / 8;
    localparam int CW     = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [PKT_W-1:0] sh;
        logic [PKT_W-1:0] work;
    } rx_st_t;

    rx_st_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (rx_valid) begin
            d.sh = {q.sh[PKT_W-9:0], rx_byte};
            if (q.cnt == CW'(NBYTES - 1)) begin
                d.cnt  = '0;
                d.work = d.sh;
                done_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        start_o = d.sh[PKT_W-NW-1 -: NW];
        work_o  = q.work;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R1: byte counter never leaves the packet range
    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CW'(NBYTES))
        else $error("p_count_range_r1");

    // R1: a completed packet shows up whole on the work output
    p_work_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (work_o[PKT_W-NW-1 -: NW] == $past(start_o)))
        else $error("p_work_load_r1");

endmodule

// File: rtl/nsc_scan.sv
module nsc_scan
    import nsc_pkg::*;
#(
    parameter int NW          = 32,
    parameter int LAT         = 6,
    parameter int REDUCED_CMP = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [NW-1:0] start_i,
    input  logic [NW-1:0] iv_i,
    input  logic [NW-1:0] sa_i,
    input  logic [NW-1:0] sb_i,
    output logic [NW-1:0] core_nonce_o,
    output logic          core_valid_o,
    output logic          idle_o,
    output logic          hit_o,
    output logic [NW-1:0] hit_nonce_o
);
    localparam int            CMP_W    = (REDUCED_CMP != 0) ? 24 : NW;
    localparam logic [NW-1:0] CMP_MASK = {NW{1'b1}} >> (NW - CMP_W);
    localparam int            DW       = $clog2(LAT + 2);
    localparam logic [NW-1:0] BACK     = NW'(LAT + 1);

    typedef struct packed {
        scan_state_e    st;
        logic [NW-1:0]  nonce;
        logic [LAT-1:0] vpipe;
        logic           hit;
        logic [DW-1:0]  drain;
    } scan_st_t;

    scan_st_t q, d;
    logic     run;
    logic     term_zero;

    always_comb begin
        d         = q;
        run       = (q.st == SC_RUN);
        term_zero = (((iv_i ^ sa_i ^ sb_i) & CMP_MASK) == '0);
        d.vpipe   = {q.vpipe[LAT-2:0], run};
        d.hit     = term_zero & q.vpipe[LAT-1];
        case (q.st)
            SC_RUN: begin
                d.nonce = q.nonce + 1'b1;
                if (q.nonce == '1) begin
                    d.st    = SC_DRAIN;
                    d.drain = DW'(LAT + 1);
                end
            end
            SC_DRAIN: begin
                d.nonce = q.nonce + 1'b1;
                if (q.drain == DW'(1)) begin
                    d.st = SC_IDLE;
                end else begin
                    d.drain = q.drain - 1'b1;
                end
            end
            default: ;
        endcase
        if (load_i) begin
            d.st    = SC_RUN;
            d.nonce = start_i;
            d.vpipe = '0;
            d.hit   = 1'b0;
            d.drain = '0;
        end
        core_nonce_o = q.nonce;
        core_valid_o = run;
        idle_o       = (q.st == SC_IDLE);
        hit_o        = q.hit & ~load_i;
        hit_nonce_o  = q.nonce - BACK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SC_IDLE, nonce: '0, vpipe: '0, hit: 1'b0, drain: '0};
        end else begin
            q <= d;
        end
    end

    // R2: a load starts the scan at the packet's nonce
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (core_valid_o && core_nonce_o == $past(start_i)))
        else $error("p_load_start_r2");

    // R3: one step per clock while scanning
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SC_RUN && !load_i && q.nonce != '1)
            |=> (core_valid_o && core_nonce_o == $past(core_nonce_o) + 1'b1))
        else $error("p_step_r3");

    // R4: a registered hit needs a valid candidate behind it
    p_hit_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.hit |-> $past(q.vpipe[LAT-1]))
        else $error("p_hit_source_r4");

    // R9: issuing the last nonce stops the scan
    p_wrap_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.nonce == '1 && !load_i) |=> !core_valid_o)
        else $error("p_wrap_stop_r9");

endmodule

// File: rtl/nsc_tx.sv
module nsc_tx #(
    parameter int NW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [NW-1:0] word_i,
    output logic [7:0]    tx_byte,
    output logic          tx_valid,
    input  logic          tx_ready
);
    localparam int NB = NW / 8;
    localparam int IW = $clog2(NB);

    typedef struct packed {
        logic          busy;
        logic [NW-1:0] sh;
        logic [IW-1:0] idx;
        logic          hv;
        logic [NW-1:0] hold;
    } tx_st_t;

    tx_st_t q, d;
    logic   fire;
    logic   last;

    always_comb begin
        d    = q;
        fire = q.busy & tx_ready;
        last = fire && (q.idx == IW'(NB - 1));
        if (fire) begin
            d.sh  = q.sh << 8;
            d.idx = q.idx + 1'b1;
        end
        if (last) begin
            d.busy = 1'b0;
            d.idx  = '0;
            if (q.hv) begin
                d.busy = 1'b1;
                d.sh   = q.hold;
                d.hv   = 1'b0;
            end
        end
        if (push_i) begin
            if (!d.busy) begin
                d.busy = 1'b1;
                d.sh   = word_i;
                d.idx  = '0;
            end else if (!d.hv) begin
                d.hv   = 1'b1;
                d.hold = word_i;
            end
        end
        tx_byte  = q.sh[NW-1 -: 8];
        tx_valid = q.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7: a stalled byte stays put
    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)))
        else $error("p_hold_byte_r7");

    // R8: with the buffer full and nothing draining, a new hit is dropped
    p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && q.busy && q.hv && !last) |=> (q.hold == $past(q.hold)))
        else $error("p_drop_full_r8");

endmodule

// File: rtl/nonce_scan_ctrl.sv
module nonce_scan_ctrl #(
    parameter int PKT_W        = 416,
    parameter int NONCE_W      = 32,
    parameter int PIPE_LATENCY = 6,
    parameter int REDUCED_CMP  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         rx_byte,
    input  logic               rx_valid,
    output logic [PKT_W-1:0]   core_work,
    output logic [NONCE_W-1:0] core_nonce,
    output logic               core_valid,
    input  logic [NONCE_W-1:0] core_iv,
    input  logic [NONCE_W-1:0] core_st_a,
    input  logic [NONCE_W-1:0] core_st_b,
    output logic [7:0]         tx_byte,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               idle
);
    logic               pkt_done;
    logic [NONCE_W-1:0] pkt_start;
    logic               hit;
    logic [NONCE_W-1:0] hit_nonce;

    nsc_pkt_rx #(.PKT_W(PKT_W), .NW(NONCE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .done_o   (pkt_done),
        .start_o  (pkt_start),
        .work_o   (core_work)
    );

    nsc_scan #(.NW(NONCE_W), .LAT(PIPE_LATENCY), .REDUCED_CMP(REDUCED_CMP)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (pkt_done),
        .start_i      (pkt_start),
        .iv_i         (core_iv),
        .sa_i         (core_st_a),
        .sb_i         (core_st_b),
        .core_nonce_o (core_nonce),
        .core_valid_o (core_valid),
        .idle_o       (idle),
        .hit_o        (hit),
        .hit_nonce_o  (hit_nonce)
    );

    nsc_tx #(.NW(NONCE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (hit),
        .word_i   (hit_nonce),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready)
    );

    // R9: nothing is issued while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !core_valid)
        else $error("p_idle_quiet_r9");

endmodule

// File: tb/tb_nonce_scan_ctrl.sv
`timescale 1ns/1ps
module tb_nonce_scan_ctrl;
    localparam int LAT = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   rx_byte = '0;
    logic         rx_valid = 1'b0;
    logic [415:0] core_work;
    logic [31:0]  core_nonce;
    logic         core_valid;
    logic [31:0]  core_iv = '0;
    logic [31:0]  core_st_a = '0;
    logic [31:0]  core_st_b = '0;
    logic [7:0]   tx_byte;
    logic         tx_valid;
    logic         tx_ready = 1'b1;
    logic         idle;

    always #2.5 clk = ~clk;

    nonce_scan_ctrl #(.PIPE_LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .core_work(core_work), .core_nonce(core_nonce), .core_valid(core_valid),
        .core_iv(core_iv), .core_st_a(core_st_a), .core_st_b(core_st_b),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .idle(idle)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [415:0] act, input logic [415:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // answer lists used by the core model
    logic [31:0] hits[$];
    logic [31:0] near[$];
    logic [31:0] results[$];

    function automatic bit in_hits(logic [31:0] v);
        foreach (hits[i]) if (hits[i] == v) return 1'b1;
        return 1'b0;
    endfunction
    function automatic bit in_near(logic [31:0] v);
        foreach (near[i]) if (near[i] == v) return 1'b1;
        return 1'b0;
    endfunction

    // reference model state
    logic [415:0] m_sh = '0, m_work = '0;
    int           m_bytes = 0;
    bit           m_scan = 0, m_idle = 1;
    logic [31:0]  m_nonce = '0;
    int           m_dcnt = 0;
    int           m_epoch = 0;
    logic [31:0]  m_q[$];
    int           m_bidx = 0;
    bit           s1_hit = 0, s2_hit = 0;
    logic [31:0]  s1_nonce = '0, s2_nonce = '0;
    int           s1_ep = 0, s2_ep = 0;
    bit           pv[LAT+1];
    logic [31:0]  pn[LAT+1];
    int           pe[LAT+1];
    logic [31:0]  rx_acc = '0;
    int           rx_cnt = 0;

    initial begin
        for (int k = 0; k <= LAT; k++) begin
            pv[k] = 0; pn[k] = '0; pe[k] = 0;
        end
    end

    // model advance at each clock edge, from bench-driven inputs only
    always @(posedge clk) begin
        if (rst_n) begin
            bit complete;
            complete = rx_valid && (m_bytes == 51);
            if (m_q.size() > 0 && tx_ready) begin
                m_bidx++;
                if (m_bidx == 4) begin
                    void'(m_q.pop_front());
                    m_bidx = 0;
                end
            end
            if (s2_hit && !complete && s2_ep == m_epoch && m_q.size() < 2)
                m_q.push_back(s2_nonce);
            s2_hit = s1_hit; s2_nonce = s1_nonce; s2_ep = s1_ep;
            if (!complete) begin
                if (m_scan) begin
                    if (m_nonce == 32'hFFFF_FFFF) begin
                        m_scan = 0;
                        m_dcnt = LAT + 1;
                    end
                    m_nonce = m_nonce + 1;
                end else if (m_dcnt > 0) begin
                    m_dcnt--;
                    if (m_dcnt == 0) m_idle = 1;
                end
            end
            if (rx_valid) begin
                m_sh = {m_sh[407:0], rx_byte};
                if (complete) begin
                    m_work  = m_sh;
                    m_bytes = 0;
                    m_epoch++;
                    m_scan  = 1;
                    m_idle  = 0;
                    m_dcnt  = 0;
                    m_nonce = m_sh[383:352];
                end else begin
                    m_bytes++;
                end
            end
        end
    end

    // compare, capture results, and act as the hash core
    always @(negedge clk) begin
        if (rst_n) begin
            chk(core_valid == m_scan, "R9 core_valid", core_valid, m_scan);
            if (m_scan) chk(core_nonce == m_nonce, "R3 core_nonce", core_nonce, m_nonce);
            chk(idle == m_idle, "R9 idle", idle, m_idle);
            chk(tx_valid == (m_q.size() > 0), "R7 tx_valid", tx_valid, m_q.size() > 0);
            if (m_q.size() > 0)
                chk(tx_byte == m_q[0][31-8*m_bidx -: 8], "R7 tx_byte", tx_byte, m_q[0][31-8*m_bidx -: 8]);
            chk(core_work == m_work, "R1 core_work", core_work, m_work);
            if (tx_valid && tx_ready) begin
                rx_acc = {rx_acc[23:0], tx_byte};
                rx_cnt++;
                if (rx_cnt == 4) begin
                    results.push_back(rx_acc);
                    rx_cnt = 0;
                end
            end
        end
        for (int k = LAT; k > 0; k--) begin
            pv[k] = pv[k-1]; pn[k] = pn[k-1]; pe[k] = pe[k-1];
        end
        pv[0] = core_valid; pn[0] = core_nonce; pe[0] = m_epoch;
        core_iv   = pn[LAT] ^ 32'h3C5A_96E1;
        core_st_a = 32'h0F0F_7788;
        if (!pv[LAT])              core_st_b = core_iv ^ core_st_a;
        else if (in_hits(pn[LAT])) core_st_b = core_iv ^ core_st_a;
        else if (in_near(pn[LAT])) core_st_b = core_iv ^ core_st_a ^ 32'h8100_0000;
        else                       core_st_b = core_iv ^ core_st_a ^ 32'h0000_0001;
        s1_hit   = pv[LAT] && in_hits(pn[LAT]);
        s1_nonce = pn[LAT];
        s1_ep    = pe[LAT];
    end

    function automatic logic [415:0] make_pkt(logic [31:0] start, logic [31:0] salt);
        return {salt ^ 32'hA5A5_0000, start, {3{salt}} ^ 96'h1234_5678_9ABC_DEF0_0F1E_2D3C,
                {8{salt ^ 32'h5566_7788}}};
    endfunction

    task automatic send_pkt(input logic [415:0] pkt, input bit gaps);
        for (int i = 0; i < 52; i++) begin
            if (gaps && (i % 7) == 3) begin
                @(negedge clk); rx_valid = 1'b0;
            end
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = pkt[415-8*i -: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        chk(core_valid == 1'b1, "R2 valid after load", core_valid, 1);
        chk(core_nonce == pkt[383:352], "R2 start nonce", core_nonce, pkt[383:352]);
        chk(core_work[415:384] == pkt[415:384], "R1 target field", core_work[415:384], pkt[415:384]);
        chk(core_work[383:352] == pkt[383:352], "R1 nonce field", core_work[383:352], pkt[383:352]);
    endtask

    task automatic expect_results(input string tag, input logic [31:0] e0, input logic [31:0] e1, input int n);
        chk(results.size() == n, tag, results.size(), n);
        if (n > 0 && results.size() > 0) chk(results[0] == e0, tag, results[0], e0);
        if (n > 1 && results.size() > 1) chk(results[1] == e1, tag, results[1], e1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] g;
        repeat (3) @(negedge clk);
        chk(idle == 1'b1, "R9 idle at reset", idle, 1);
        chk(core_valid == 1'b0, "R9 no issue at reset", core_valid, 0);
        chk(tx_valid == 1'b0, "R7 tx quiet at reset", tx_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: start one below the answer, bytes with gaps
        g = 32'h0046_8BB4;
        hits.delete(); near.delete();
        send_pkt(make_pkt(g - 1, 32'h1111_0001), 1'b1);
        results.delete(); hits.push_back(g);
        repeat (40) @(negedge clk);
        expect_results("R5 start-1", g, 0, 1);

        // R5: start two below
        g = 32'h0100_0020;
        hits.delete();
        send_pkt(make_pkt(g - 2, 32'h2222_0002), 1'b0);
        results.delete(); hits.push_back(g);
        repeat (40) @(negedge clk);
        expect_results("R5 start-2", g, 0, 1);

        // R5: start exactly on the answer
        g = 32'h0200_0300;
        hits.delete();
        send_pkt(make_pkt(g, 32'h3333_0003), 1'b0);
        results.delete(); hits.push_back(g);
        repeat (40) @(negedge clk);
        expect_results("R5 start-0", g, 0, 1);

        // R4: near miss in bits 31:24 is not a hit
        g = 32'h0300_0400;
        hits.delete();
        send_pkt(make_pkt(g - 2, 32'h4444_0004), 1'b0);
        results.delete(); near.push_back(g); hits.push_back(g + 3);
        repeat (40) @(negedge clk);
        expect_results("R4 near miss", g + 3, 0, 1);
        near.delete();

        // R8: three hits against a stalled transmitter
        g = 32'h0400_0500;
        hits.delete();
        send_pkt(make_pkt(g - 1, 32'h5555_0005), 1'b0);
        results.delete();
        hits.push_back(g); hits.push_back(g + 2); hits.push_back(g + 4);
        @(posedge clk); #1 tx_ready = 1'b0;
        repeat (20) @(negedge clk);
        chk(tx_valid == 1'b1, "R7 stalled valid", tx_valid, 1);
        chk(tx_byte == g[31:24], "R7 stalled msb", tx_byte, g[31:24]);
        @(posedge clk); #1 tx_ready = 1'b1;
        repeat (30) @(negedge clk);
        expect_results("R8 buffer and drop", g, g + 2, 2);

        // R6: new packet lands while an old hit is in flight
        g = 32'h0500_0600;
        hits.delete();
        hits.push_back(g); hits.push_back(g + 32'h1000);
        send_pkt(make_pkt(g - 48, 32'h6666_0006), 1'b0);
        send_pkt(make_pkt(g + 32'h1000 - 1, 32'h7777_0007), 1'b0);
        results.delete();
        repeat (30) @(negedge clk);
        expect_results("R6 abort", g + 32'h1000, 0, 1);

        // R9: wrap, last two candidates hit, nonce 0 never issued
        hits.delete();
        send_pkt(make_pkt(32'hFFFF_FFF8, 32'h8888_0008), 1'b0);
        results.delete();
        hits.push_back(32'hFFFF_FFFE); hits.push_back(32'hFFFF_FFFF); hits.push_back(32'h0);
        repeat (40) @(negedge clk);
        expect_results("R9 wrap results", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 2);
        chk(idle == 1'b1, "R9 idle after wrap", idle, 1);
        chk(core_valid == 1'b0, "R9 stopped after wrap", core_valid, 0);

        // R2: restart from idle
        hits.delete();
        send_pkt(make_pkt(32'h0000_1000, 32'h9999_0009), 1'b0);
        repeat (10) @(negedge clk);
        chk(idle == 1'b0, "R2 busy after restart", idle, 0);

        finish_run();
    end
endmodule